// File: doc/BRIEF.md
# Trip Output Action Selector

This block sits at the end of a PWM channel and decides what each of its two pins, A and B, shows while a protection trip is active. It receives the normal A and B waveforms, the combined trip indications from the trip latch controller (cycle-by-cycle and one-shot), four direct compare event indications, and the counter direction. Every active trip source contributes a 2-bit action code for each pin. The selected code makes the pin float, drives it high, drives it low, or lets the normal waveform through.

Each pin has its own code field for the combined trip and its own field for each compare event. An extended mode bit replaces these single codes with a pair of codes per source, one used while the counter counts up and one used while it counts down. When several sources are active on one pin, a fixed priority picks the result. The path has no register, so a trip reaches the pins in the same cycle it arrives, without waiting for any PWM period boundary.

Top module: `trip_out_sel`

## Requirements
- R1: Action code 00 puts a pin into high impedance. Its output enable goes low and its value output is driven low.
- R2: Action code 01 drives the pin high and code 10 drives it low, both with the output enable high.
- R3: Action code 11 leaves the pin unchanged. The value output follows the pin's normal waveform and the enable is high.
- R4: The combined trip is active when either the cycle-by-cycle or the one-shot input is high. It applies pin A's code from bits [1:0] of the combined-trip code bus and pin B's code from bits [3:2].
- R5: Each compare event e (0..3) that is high applies its own code. Pin A's code for event e is at bits [2e+1:2e] of a compare code bus and pin B's code is at bits [2e+9:2e+8]. An event that is low has no effect.
- R6: With the extended mode bit high, the up-count codes apply while the direction input is 0 and the down-count codes apply while it is 1. The single codes are then ignored.
- R7: With the extended mode bit low, the single codes apply and the up-count and down-count codes are ignored.
- R8: When several active sources give a pin different codes, high impedance wins over force low, force low wins over force high, and force high wins over no change.
- R9: With no trip source active, both pins follow their normal waveforms with the enable high, whatever the codes are.
- R10: A change on a trip input, a code or the direction input shows at the pins in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pwm_i | input | 2 | Normal waveforms, bit 0 = A, bit 1 = B |
| cbc_trip_i | input | 1 | Cycle-by-cycle trip active |
| ost_trip_i | input | 1 | One-shot trip active |
| dc_evt_i | input | 4 | Direct compare events, one bit per event |
| cnt_dn_i | input | 1 | Counter direction, 1 = counting down |
| ext_mode_i | input | 1 | Selects the per-direction codes |
| trip_std_i | input | 4 | Combined-trip single codes, A [1:0], B [3:2] |
| trip_up_i | input | 4 | Combined-trip up-count codes, same layout |
| trip_dn_i | input | 4 | Combined-trip down-count codes, same layout |
| dc_std_i | input | 16 | Compare-event single codes, A [7:0], B [15:8], 2 bits per event |
| dc_up_i | input | 16 | Compare-event up-count codes, same layout |
| dc_dn_i | input | 16 | Compare-event down-count codes, same layout |
| pwm_o | output | 2 | Pin values, bit 0 = A, bit 1 = B |
| pwm_oe_o | output | 2 | Pin output enables, 0 = high impedance |

## Verification
The assertions run on every evaluation. They check that a floating pin drives its value low, that a no-change result passes the waveform through, that an active high-impedance code always wins the merge, and that both pins follow their waveforms when no source is active. Only the bench scenarios can show that the right code field is taken for each source and pin, that the direction input picks between the up and down codes in extended mode, that the unused code sets are ignored, and how force low, force high and no change rank against one another.

// File: rtl/trip_act_pkg.sv
package trip_act_pkg;
  typedef enum logic [1:0] {
    ACT_HIZ  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_KEEP = 2'b11
  } act_e;
endpackage

// File: rtl/trip_code_sel.sv
module trip_code_sel #(
  parameter int N_SRC = 5,
  localparam int W = 2 * N_SRC
) (
  input  logic         ext_i,
  input  logic         dn_i,
  input  logic [W-1:0] std_i,
  input  logic [W-1:0] up_i,
  input  logic [W-1:0] dnc_i,
  output logic [W-1:0] code_o
);
  always_comb begin
    if (!ext_i)    code_o = std_i;
    else if (dn_i) code_o = dnc_i;
    else           code_o = up_i;
  end
endmodule

// File: rtl/trip_prio_merge.sv
module trip_prio_merge
  import trip_act_pkg::*;
#(
  parameter int N_SRC = 5
) (
  input  logic [N_SRC-1:0]   act_i,
  input  logic [2*N_SRC-1:0] code_i,
  output act_e               code_o
);
  logic [N_SRC-1:0] hit_hiz, hit_low, hit_high;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign hit_hiz[s]  = act_i[s] && (code_i[2*s +: 2] == ACT_HIZ);
    assign hit_low[s]  = act_i[s] && (code_i[2*s +: 2] == ACT_LOW);
    assign hit_high[s] = act_i[s] && (code_i[2*s +: 2] == ACT_HIGH);
  end

  // fixed ranking: float > low > high > keep
  always_comb begin
    if (|hit_hiz)       code_o = ACT_HIZ;
    else if (|hit_low)  code_o = ACT_LOW;
    else if (|hit_high) code_o = ACT_HIGH;
    else                code_o = ACT_KEEP;
  end

  always_comb begin
    if (act_i[0] && code_i[1:0] == ACT_HIZ)
      a_r8_hiz_wins: assert (code_o == ACT_HIZ);
    if (act_i == '0)
      a_r9_idle_keep: assert (code_o == ACT_KEEP);
  end
endmodule

// File: rtl/trip_pin_drive.sv
module trip_pin_drive
  import trip_act_pkg::*;
(
  input  logic pwm_i,
  input  act_e code_i,
  output logic pwm_o,
  output logic oe_o
);
  always_comb begin
    pwm_o = pwm_i;
    oe_o  = 1'b1;
    case (code_i)
      ACT_HIZ:  begin pwm_o = 1'b0; oe_o = 1'b0; end
      ACT_HIGH: pwm_o = 1'b1;
      ACT_LOW:  pwm_o = 1'b0;
      default:  pwm_o = pwm_i;
    endcase
  end

  always_comb begin
    if (!oe_o)
      a_r1_float_low: assert (!pwm_o);
    if (code_i == ACT_KEEP)
      a_r3_keep_pass: assert (pwm_o == pwm_i && oe_o);
  end
endmodule

// File: rtl/trip_out_sel.sv
module trip_out_sel
  import trip_act_pkg::*;
#(
  parameter int N_OUT = 2,
  parameter int N_DC  = 4,
  localparam int N_SRC = N_DC + 1,
  localparam int TW    = 2 * N_OUT,
  localparam int DW    = 2 * N_DC * N_OUT
) (
  input  logic [N_OUT-1:0] pwm_i,
  input  logic             cbc_trip_i,
  input  logic             ost_trip_i,
  input  logic [N_DC-1:0]  dc_evt_i,
  input  logic             cnt_dn_i,
  input  logic             ext_mode_i,
  input  logic [TW-1:0]    trip_std_i,
  input  logic [TW-1:0]    trip_up_i,
  input  logic [TW-1:0]    trip_dn_i,
  input  logic [DW-1:0]    dc_std_i,
  input  logic [DW-1:0]    dc_up_i,
  input  logic [DW-1:0]    dc_dn_i,
  output logic [N_OUT-1:0] pwm_o,
  output logic [N_OUT-1:0] pwm_oe_o
);
  logic             trip_any;
  logic [N_SRC-1:0] src_act;

  assign trip_any = cbc_trip_i | ost_trip_i;
  assign src_act  = {dc_evt_i, trip_any};

  for (genvar o = 0; o < N_OUT; o++) begin : g_pin
    logic [2*N_SRC-1:0] std_v, up_v, dn_v, code_v;
    act_e               merged;

    assign std_v = {dc_std_i[2*N_DC*o +: 2*N_DC], trip_std_i[2*o +: 2]};
    assign up_v  = {dc_up_i[2*N_DC*o +: 2*N_DC],  trip_up_i[2*o +: 2]};
    assign dn_v  = {dc_dn_i[2*N_DC*o +: 2*N_DC],  trip_dn_i[2*o +: 2]};

    trip_code_sel #(.N_SRC(N_SRC)) u_sel (
      .ext_i (ext_mode_i),
      .dn_i  (cnt_dn_i),
      .std_i (std_v),
      .up_i  (up_v),
      .dnc_i (dn_v),
      .code_o(code_v)
    );

    trip_prio_merge #(.N_SRC(N_SRC)) u_merge (
      .act_i (src_act),
      .code_i(code_v),
      .code_o(merged)
    );

    trip_pin_drive u_drv (
      .pwm_i (pwm_i[o]),
      .code_i(merged),
      .pwm_o (pwm_o[o]),
      .oe_o  (pwm_oe_o[o])
    );
  end

  always_comb begin
    if (!cbc_trip_i && !ost_trip_i && dc_evt_i == '0)
      a_r9_no_trip_follow: assert (pwm_o == pwm_i && pwm_oe_o == '1);
  end
endmodule

// File: tb/tb_trip_out_sel.sv
module tb_trip_out_sel;
  logic        clk = 1'b0;
  logic [1:0]  pwm_i = '0;
  logic        cbc_trip_i = 1'b0, ost_trip_i = 1'b0;
  logic [3:0]  dc_evt_i = '0;
  logic        cnt_dn_i = 1'b0, ext_mode_i = 1'b0;
  logic [3:0]  trip_std_i = '1, trip_up_i = '1, trip_dn_i = '1;
  logic [15:0] dc_std_i = '1, dc_up_i = '1, dc_dn_i = '1;
  logic [1:0]  pwm_o, pwm_oe_o;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trip_out_sel dut (.*);

  task automatic check(string rq, logic [1:0] ev, logic [1:0] eoe);
    checks++;
    if (pwm_o !== ev || pwm_oe_o !== eoe) begin
      errors++;
      $display("FAIL %s: val=%b oe=%b expected val=%b oe=%b", rq, pwm_o, pwm_oe_o, ev, eoe);
    end
  endtask

  task automatic idle_all();
    @(posedge clk);
    cbc_trip_i = 0; ost_trip_i = 0; dc_evt_i = '0; ext_mode_i = 0; cnt_dn_i = 0;
    trip_std_i = '1; trip_up_i = '1; trip_dn_i = '1;
    dc_std_i = '1; dc_up_i = '1; dc_dn_i = '1;
  endtask

  task automatic t_idle();
    idle_all();
    trip_std_i = 4'b0000; dc_std_i = '0; pwm_i = 2'b10;
    #1 check("R9 idle follow", 2'b10, 2'b11);
    pwm_i = 2'b01;
    #1 check("R9 idle follow toggled", 2'b01, 2'b11);
  endtask

  task automatic t_codes();
    idle_all();
    pwm_i = 2'b10;
    trip_std_i = {2'b01, 2'b00}; cbc_trip_i = 1;
    #1 check("R1 A float, R2 B high", 2'b10, 2'b10);
    trip_std_i = {2'b11, 2'b10};
    #1 check("R2 A low, R3 B keep", 2'b10, 2'b11);
    pwm_i = 2'b00;
    #1 check("R3 B follows waveform", 2'b00, 2'b11);
  endtask

  task automatic t_ost();
    idle_all();
    pwm_i = 2'b01; trip_std_i = {2'b10, 2'b01}; ost_trip_i = 1;
    #1 check("R4 one-shot A high B low", 2'b01, 2'b11);
    trip_std_i = {2'b00, 2'b11};
    #1 check("R4 one-shot B float A keep", 2'b01, 2'b01);
  endtask

  task automatic t_dc();
    idle_all();
    pwm_i = 2'b11;
    dc_std_i = 16'h0000;
    dc_std_i[5:4] = 2'b10;   // A event 2 low
    dc_std_i[13:12] = 2'b11; // B event 2 keep
    dc_evt_i = 4'b0100;
    #1 check("R5 event 2 A low B keep", 2'b10, 2'b11);
    dc_evt_i = 4'b0001;
    #1 check("R5 event 0 both float", 2'b00, 2'b00);
  endtask

  task automatic t_ext();
    idle_all();
    pwm_i = 2'b00;
    trip_std_i = {2'b00, 2'b00};
    trip_up_i  = {2'b10, 2'b01};
    trip_dn_i  = {2'b01, 2'b10};
    ext_mode_i = 1; cbc_trip_i = 1;
    #1 check("R6 up-count codes", 2'b01, 2'b11);
    cnt_dn_i = 1;
    #1 check("R6 R10 down-count codes same cycle", 2'b10, 2'b11);
    ext_mode_i = 0;
    #1 check("R7 single codes float", 2'b00, 2'b00);
    trip_std_i = {2'b01, 2'b01}; trip_up_i = '0; trip_dn_i = '0;
    #1 check("R7 up/down codes ignored", 2'b11, 2'b11);
  endtask

  task automatic t_prio();
    idle_all();
    pwm_i = 2'b00;
    trip_std_i = {2'b01, 2'b01};          // both high
    dc_std_i[1:0] = 2'b10;                // A event 0 low
    dc_std_i[3:2] = 2'b11;                // A event 1 keep
    dc_std_i[5:4] = 2'b00;                // A event 2 float
    cbc_trip_i = 1; dc_evt_i = 4'b0011;
    #1 check("R8 low beats high, high beats keep", 2'b10, 2'b11);
    dc_evt_i = 4'b0111;
    #1 check("R8 float beats all", 2'b10, 2'b10);
    cbc_trip_i = 0; dc_evt_i = 4'b0010;
    #1 check("R8 keep alone passes", 2'b00, 2'b11);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_codes();
    t_ost();
    t_dc();
    t_ext();
    t_prio();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule